// File: doc/BRIEF.md
# Self-Running Pattern DMA Bus Master

This block is a 32-bit bus master that exercises a memory slave over a Wishbone-style master interface without any software set-up. It writes a fixed run of eight words to a parameterised base address. It then reads the same eight locations back and compares every returned word with the word it wrote. It repeats this write-then-read pass for as long as it runs. A sticky flag records any read-back word that differs from the expected word. Several instances with different base addresses and instance numbers can sit on one shared bus, so that the interconnect and its arbiter can be tested under load.

A mode pin picks the cycle style. In burst style, all eight write beats travel inside one bus cycle, and all eight read beats travel inside a second cycle. In single style, every beat is a bus cycle of its own. Each cycle starts only after an external grant is seen. Between cycles the engine always releases the cycle line for at least one clock, so that a shared-bus arbiter can hand the bus to another master. All bus outputs come from registers, and the reset is synchronous and active high.

Top module: `pattern_dma_master`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `cyc_o`, `stb_o`, `we_o` and `mismatch` low. After reset the first beat is a write to the base address.
- R2: A bus cycle begins only after a clock edge at which `bus_gnt` is high while the engine is idle. While the grant stays low, `cyc_o` and `stb_o` stay low.
- R3: With `burst_mode` high, a pass is one cycle of eight write beats at word addresses BASE_ADDR+k (k = 0..7), followed by a separate cycle of eight read beats at the same addresses in the same order. Passes repeat.
- R4: With `burst_mode` low, every beat is its own bus cycle, and the beats follow the same write-then-read address order as R3.
- R5: Once `stb_o` is high, it stays high and `adr_o`, `dat_o` and `we_o` hold their values until `ack_i` is sampled high. Each accepted beat advances the address by ADDR_STEP (1 by default).
- R6: The write word for beat k is PATTERN ^ (k << 16), where PATTERN is BASE_PATTERN with its low nibble replaced by INST_ID (default 32'hA5A5A5A1). `sel_o` is 4'hF while `stb_o` is high. `we_o` is 1 for write beats and 0 for read beats.
- R7: After the acknowledge that ends a cycle, `cyc_o` is low for at least one clock. `stb_o` is never high without `cyc_o`. A cycle never carries more than eight beats.
- R8: `mismatch` rises when a read beat is accepted whose `dat_i` differs from the word written to that location. It then stays high until reset.
- R9: `burst_mode` is sampled only when a cycle starts. Changing it during a cycle does not alter that cycle's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_gnt | input | 1 | Grant from the bus arbiter; needed to start a cycle |
| burst_mode | input | 1 | 1 = eight-beat cycles, 0 = one beat per cycle |
| ack_i | input | 1 | Slave acknowledge |
| dat_i | input | 32 | Read data from the slave |
| adr_o | output | 32 | Word address |
| dat_o | output | 32 | Write data |
| we_o | output | 1 | Write enable |
| sel_o | output | 4 | Byte selects |
| stb_o | output | 1 | Strobe |
| cyc_o | output | 1 | Bus cycle active |
| mismatch | output | 1 | Sticky read-back mismatch flag |

## Verification
The assertions assume that the slave raises `ack_i` only while `stb_o` is high, and that the arbiter keeps `bus_gnt` high for as long as the engine holds `cyc_o`. The bench's slave model acknowledges only a strobe it has seen on a falling edge. It drops the acknowledge again after every beat and can insert wait states. The grant is changed only while the engine is idle or held in reset, so every stimulus stays within these assumptions.

// File: rtl/pdm_pkg.sv
package pdm_pkg;

  // Bus-side state of the master: released or holding a cycle.
  typedef enum logic {
    BUS_IDLE   = 1'b0,
    BUS_ACTIVE = 1'b1
  } bus_state_e;

  // Where the sequencer stands inside a pass.
  typedef struct packed {
    logic rd_phase;  // 0: write half, 1: read-back half
    logic blk;       // cycle style latched at cycle start
  } pass_ctl_t;

endpackage

// File: rtl/pdm_seq.sv
// Beat and phase sequencer: tracks which beat of the pass is next and
// whether the current cycle is a burst or a single-beat cycle.
module pdm_seq
  import pdm_pkg::*;
#(
  parameter int BEATS = 8,
  parameter int IW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,     // a cycle begins at this edge
  input  logic          adv,       // a beat is accepted at this edge
  input  logic          mode_in,   // 1 = burst cycles
  output logic [IW-1:0] beat,
  output logic [IW-1:0] beat_nxt,
  output logic          rd_phase,
  output logic          cyc_last   // the current beat closes the cycle
);

  localparam logic [IW-1:0] LAST_BEAT = IW'(BEATS - 1);

  logic [IW-1:0] beat_q;
  pass_ctl_t     ctl_q;
  logic          pass_end;

  assign pass_end = (beat_q == LAST_BEAT);
  assign beat     = beat_q;
  assign beat_nxt = beat_q + IW'(1);
  assign rd_phase = ctl_q.rd_phase;
  // A single-beat cycle ends on every beat; a burst ends with the pass half.
  assign cyc_last = ctl_q.blk ? pass_end : 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      beat_q <= '0;
      ctl_q  <= '0;
    end else begin
      if (start) begin
        ctl_q.blk <= mode_in;
      end
      if (adv) begin
        if (pass_end) begin
          beat_q         <= '0;
          ctl_q.rd_phase <= ~ctl_q.rd_phase;
        end else begin
          beat_q <= beat_nxt;
        end
      end
    end
  end

endmodule

// File: rtl/pdm_pattern.sv
// Maps a beat number onto its word address and its write word.
module pdm_pattern #(
  parameter int              ADDR_W     = 32,
  parameter int              DATA_W     = 32,
  parameter int              IW         = 3,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int              ADDR_STEP  = 1,
  parameter logic [DATA_W-1:0] PATTERN  = '0,
  parameter int              WORD_SHIFT = 16
) (
  input  logic [IW-1:0]     beat,
  output logic [ADDR_W-1:0] adr,
  output logic [DATA_W-1:0] word
);

  assign adr  = BASE_ADDR + (ADDR_W'(beat) * ADDR_W'(ADDR_STEP));
  assign word = PATTERN ^ (DATA_W'(beat) << WORD_SHIFT);

endmodule

// File: rtl/pdm_bus.sv
// Registered bus side: starts cycles on grant, holds each beat until it is
// acknowledged, then either loads the next beat or releases the bus.
module pdm_bus
  import pdm_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int SEL_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              gnt,
  input  logic              ack_i,
  input  logic              rd_phase,
  input  logic              cyc_last,
  input  logic [ADDR_W-1:0] cur_adr,
  input  logic [DATA_W-1:0] cur_dat,
  input  logic [ADDR_W-1:0] nxt_adr,
  input  logic [DATA_W-1:0] nxt_dat,
  output logic              start,
  output logic              adv,
  output logic              cyc_o,
  output logic              stb_o,
  output logic              we_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [ADDR_W-1:0] adr_o,
  output logic [DATA_W-1:0] dat_o
);

  bus_state_e state_q;

  assign start = (state_q == BUS_IDLE) && gnt;
  assign adv   = (state_q == BUS_ACTIVE) && ack_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= BUS_IDLE;
      cyc_o   <= 1'b0;
      stb_o   <= 1'b0;
      we_o    <= 1'b0;
      sel_o   <= '0;
      adr_o   <= '0;
      dat_o   <= '0;
    end else begin
      unique case (state_q)
        BUS_IDLE: begin
          if (start) begin
            state_q <= BUS_ACTIVE;
            cyc_o   <= 1'b1;
            stb_o   <= 1'b1;
            we_o    <= ~rd_phase;
            sel_o   <= '1;
            adr_o   <= cur_adr;
            dat_o   <= rd_phase ? '0 : cur_dat;
          end
        end
        BUS_ACTIVE: begin
          if (ack_i) begin
            if (cyc_last) begin
              // Release so an arbiter can pass the bus on.
              state_q <= BUS_IDLE;
              cyc_o   <= 1'b0;
              stb_o   <= 1'b0;
              we_o    <= 1'b0;
              sel_o   <= '0;
            end else begin
              adr_o <= nxt_adr;
              dat_o <= rd_phase ? '0 : nxt_dat;
            end
          end
        end
        default: state_q <= BUS_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pdm_cmp.sv
// Read-back checker: compares each accepted read word with its expected word.
module pdm_cmp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  input  logic              rd_phase,
  input  logic [DATA_W-1:0] rd_data,
  input  logic [DATA_W-1:0] expect_word,
  output logic              mismatch
);

  logic diff;

  assign diff = adv && rd_phase && (rd_data != expect_word);

  always_ff @(posedge clk) begin
    if (rst) begin
      mismatch <= 1'b0;
    end else if (diff) begin
      mismatch <= 1'b1;
    end
  end

endmodule

// File: rtl/pattern_dma_master.sv
// Self-running test-pattern bus master: write pass, read-back pass, repeat.
module pattern_dma_master #(
  parameter int                ADDR_W       = 32,
  parameter int                DATA_W       = 32,
  parameter int                BEATS        = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR    = 32'h0000_0008,
  parameter int                ADDR_STEP    = 1,
  parameter logic [DATA_W-1:0] BASE_PATTERN = 32'hA5A5_A5A0,
  parameter logic [3:0]        INST_ID      = 4'h1,
  parameter int                WORD_SHIFT   = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_gnt,
  input  logic                  burst_mode,
  input  logic                  ack_i,
  input  logic [DATA_W-1:0]     dat_i,
  output logic [ADDR_W-1:0]     adr_o,
  output logic [DATA_W-1:0]     dat_o,
  output logic                  we_o,
  output logic [DATA_W/8-1:0]   sel_o,
  output logic                  stb_o,
  output logic                  cyc_o,
  output logic                  mismatch
);

  localparam int                IW      = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam int                SEL_W   = DATA_W / 8;
  localparam logic [DATA_W-1:0] PATTERN = {BASE_PATTERN[DATA_W-1:4], INST_ID};

  logic              start;
  logic              adv;
  logic [IW-1:0]     beat;
  logic [IW-1:0]     beat_nxt;
  logic              rd_phase;
  logic              cyc_last;
  logic [ADDR_W-1:0] cur_adr;
  logic [ADDR_W-1:0] nxt_adr;
  logic [DATA_W-1:0] cur_dat;
  logic [DATA_W-1:0] nxt_dat;

  pdm_seq #(
    .BEATS (BEATS),
    .IW    (IW)
  ) u_seq (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .adv      (adv),
    .mode_in  (burst_mode),
    .beat     (beat),
    .beat_nxt (beat_nxt),
    .rd_phase (rd_phase),
    .cyc_last (cyc_last)
  );

  // Two copies of the pattern map: the beat being issued and the one after.
  for (genvar g = 0; g < 2; g++) begin : g_pat
    logic [ADDR_W-1:0] p_adr;
    logic [DATA_W-1:0] p_word;
    pdm_pattern #(
      .ADDR_W     (ADDR_W),
      .DATA_W     (DATA_W),
      .IW         (IW),
      .BASE_ADDR  (BASE_ADDR),
      .ADDR_STEP  (ADDR_STEP),
      .PATTERN    (PATTERN),
      .WORD_SHIFT (WORD_SHIFT)
    ) u_pat (
      .beat (g == 0 ? beat : beat_nxt),
      .adr  (p_adr),
      .word (p_word)
    );
  end

  assign cur_adr = g_pat[0].p_adr;
  assign cur_dat = g_pat[0].p_word;
  assign nxt_adr = g_pat[1].p_adr;
  assign nxt_dat = g_pat[1].p_word;

  pdm_bus #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .SEL_W  (SEL_W)
  ) u_bus (
    .clk      (clk),
    .rst      (rst),
    .gnt      (bus_gnt),
    .ack_i    (ack_i),
    .rd_phase (rd_phase),
    .cyc_last (cyc_last),
    .cur_adr  (cur_adr),
    .cur_dat  (cur_dat),
    .nxt_adr  (nxt_adr),
    .nxt_dat  (nxt_dat),
    .start    (start),
    .adv      (adv),
    .cyc_o    (cyc_o),
    .stb_o    (stb_o),
    .we_o     (we_o),
    .sel_o    (sel_o),
    .adr_o    (adr_o),
    .dat_o    (dat_o)
  );

  pdm_cmp #(
    .DATA_W (DATA_W)
  ) u_cmp (
    .clk         (clk),
    .rst         (rst),
    .adv         (adv),
    .rd_phase    (rd_phase),
    .rd_data     (dat_i),
    .expect_word (cur_dat),
    .mismatch    (mismatch)
  );

endmodule

// File: rtl/pdm_props.sv
// Protocol checker for pattern_dma_master, attached by bind below.
module pdm_props #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BEATS  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_gnt,
  input logic              ack_i,
  input logic [ADDR_W-1:0] adr_o,
  input logic [DATA_W-1:0] dat_o,
  input logic              we_o,
  input logic [DATA_W/8-1:0] sel_o,
  input logic              stb_o,
  input logic              cyc_o,
  input logic              mismatch
);

  localparam int CW = $clog2(BEATS + 1) + 1;

  // Acknowledges counted inside the current cycle.
  logic [CW-1:0] acks_q;
  always_ff @(posedge clk) begin
    if (rst || !cyc_o) begin
      acks_q <= '0;
    end else if (ack_i && stb_o) begin
      acks_q <= acks_q + CW'(1);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!cyc_o && !stb_o && !we_o && !mismatch));

  assert_start_on_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(cyc_o) |-> $past(bus_gnt));

  assert_hold_until_ack_R5: assert property (@(posedge clk) disable iff (rst)
    (stb_o && !ack_i) |=> (stb_o && $stable(adr_o) && $stable(dat_o) && $stable(we_o)));

  assert_full_select_R6: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> (sel_o == '1));

  assert_dir_fixed_in_cycle_R6: assert property (@(posedge clk) disable iff (rst)
    (cyc_o && !(ack_i && stb_o)) |=> (!cyc_o || $stable(we_o)));

  assert_stb_needs_cyc_R7: assert property (@(posedge clk) disable iff (rst)
    stb_o |-> cyc_o);

  assert_beat_limit_R7: assert property (@(posedge clk) disable iff (rst)
    cyc_o |-> (acks_q < CW'(BEATS)));

  assert_release_after_burst_R7: assert property (@(posedge clk) disable iff (rst)
    (cyc_o && stb_o && ack_i && acks_q == CW'(BEATS - 1)) |=> !cyc_o);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> mismatch);

  assert_flag_from_read_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mismatch) |-> $past(stb_o && ack_i && !we_o));

endmodule

bind pattern_dma_master pdm_props #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .BEATS  (BEATS)
) u_props (
  .clk      (clk),
  .rst      (rst),
  .bus_gnt  (bus_gnt),
  .ack_i    (ack_i),
  .adr_o    (adr_o),
  .dat_o    (dat_o),
  .we_o     (we_o),
  .sel_o    (sel_o),
  .stb_o    (stb_o),
  .cyc_o    (cyc_o),
  .mismatch (mismatch)
);

// File: tb/sim_pattern_dma_master.sv
module sim_pattern_dma_master;

  localparam logic [31:0] BASE = 32'h0000_0008;
  localparam logic [31:0] PAT  = 32'hA5A5_A5A1;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_gnt = 1'b0;
  logic        burst_mode = 1'b1;
  logic        ack_i = 1'b0;
  logic [31:0] dat_i = '0;
  logic [31:0] adr_o;
  logic [31:0] dat_o;
  logic        we_o;
  logic [3:0]  sel_o;
  logic        stb_o;
  logic        cyc_o;
  logic        mismatch;

  always #10 clk = ~clk;  // 50 MHz

  pattern_dma_master u0 (
    .clk (clk), .rst (rst), .bus_gnt (bus_gnt), .burst_mode (burst_mode),
    .ack_i (ack_i), .dat_i (dat_i), .adr_o (adr_o), .dat_o (dat_o),
    .we_o (we_o), .sel_o (sel_o), .stb_o (stb_o), .cyc_o (cyc_o),
    .mismatch (mismatch)
  );

  int n_chk = 0;
  int n_bad = 0;

  // Slave model state and transfer log.
  logic [31:0] mem [0:7];
  logic [31:0] lg_adr [0:63];
  logic [31:0] lg_dat [0:63];
  logic        lg_we  [0:63];
  int          lg_cyc [0:63];
  int          log_n = 0;
  int          ncyc = 0;
  int          cyc_seen = 0;
  int          sel_bad = 0;
  int          hold_bad = 0;
  int          wait_n = 0;
  int          corrupt_idx = -1;

  function automatic logic [31:0] word_of(int k);
    return PAT ^ (32'(k) << 16);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Slave: acknowledges at falling edges, optional wait states, logs beats.
  initial begin
    int          wcnt = 0;
    logic        cyc_prev = 1'b0;
    logic        hold_pend = 1'b0;
    logic [31:0] h_adr = '0;
    logic [31:0] h_dat = '0;
    logic        h_we = 1'b0;
    forever begin
      @(negedge clk);
      if (rst) begin
        ack_i = 1'b0; wcnt = 0; cyc_prev = 1'b0; hold_pend = 1'b0;
      end else begin
        if (cyc_o && !cyc_prev) ncyc++;
        cyc_prev = cyc_o;
        if (cyc_o) cyc_seen++;
        if (stb_o && sel_o != 4'hF) sel_bad++;
        if (hold_pend && (!stb_o || adr_o != h_adr || dat_o != h_dat || we_o != h_we))
          hold_bad++;
        hold_pend = 1'b0;
        if (ack_i) begin
          ack_i = 1'b0;
        end else if (cyc_o && stb_o) begin
          if (wcnt < wait_n) begin
            wcnt++;
            hold_pend = 1'b1; h_adr = adr_o; h_dat = dat_o; h_we = we_o;
          end else begin
            logic [31:0] idx;
            idx = adr_o - BASE;
            wcnt = 0;
            ack_i = 1'b1;
            if (we_o) mem[idx[2:0]] = dat_o;
            else dat_i = mem[idx[2:0]] ^ ((int'(idx) == corrupt_idx) ? 32'h1 : 32'h0);
            if (log_n < 64) begin
              lg_adr[log_n] = adr_o; lg_dat[log_n] = dat_o;
              lg_we[log_n] = we_o;   lg_cyc[log_n] = ncyc;
              log_n++;
            end
          end
        end
      end
    end
  end

  task automatic do_reset(input logic g, input logic m);
    @(negedge clk);
    rst = 1'b1;
    bus_gnt = g;
    burst_mode = m;
    repeat (3) @(negedge clk);
    log_n = 0; ncyc = 0; cyc_seen = 0; sel_bad = 0; hold_bad = 0;
    rst = 1'b0;
  endtask

  task automatic wait_beats(input int n);
    int guard = 0;
    while (log_n < n && guard < 5000) begin
      @(posedge clk); #2;
      guard++;
    end
    check(log_n >= n, "R3", "beats logged before timeout", 32'(log_n), 32'(n));
  endtask

  task automatic t_reset;
    do_reset(1'b1, 1'b1);
    #2;
    check(!cyc_o && !stb_o, "R1", "cyc/stb low after reset", {cyc_o, stb_o}, 0);
    check(!we_o, "R1", "we low after reset", we_o, 0);
    check(!mismatch, "R1", "flag clear after reset", mismatch, 0);
  endtask

  task automatic t_no_grant;
    do_reset(1'b0, 1'b1);
    repeat (20) @(posedge clk);
    #2;
    check(cyc_seen == 0, "R2", "cycles seen without grant", 32'(cyc_seen), 0);
    check(log_n == 0, "R2", "beats without grant", 32'(log_n), 0);
    @(negedge clk);
    bus_gnt = 1'b1;
    @(posedge clk); #2;
    check(cyc_o && stb_o, "R2", "cycle begins after grant", {cyc_o, stb_o}, 2'b11);
  endtask

  task automatic t_block;
    do_reset(1'b1, 1'b1);
    wait_beats(16);
    check(lg_adr[0] == BASE && lg_we[0], "R1", "first beat write at base", lg_adr[0], BASE);
    for (int k = 0; k < 8; k++) begin
      check(lg_we[k] == 1'b1, "R6", "write beat we", lg_we[k], 1);
      check(lg_adr[k] == BASE + 32'(k), "R3", "write address", lg_adr[k], BASE + 32'(k));
      check(lg_dat[k] == word_of(k), "R6", "write word", lg_dat[k], word_of(k));
      check(lg_cyc[k] == 1, "R3", "write beats share cycle", 32'(lg_cyc[k]), 1);
      check(lg_we[8+k] == 1'b0, "R6", "read beat we", lg_we[8+k], 0);
      check(lg_adr[8+k] == BASE + 32'(k), "R3", "read address", lg_adr[8+k], BASE + 32'(k));
      check(lg_cyc[8+k] == 2, "R3", "read beats share cycle", 32'(lg_cyc[8+k]), 2);
    end
    check(lg_cyc[8] != lg_cyc[7], "R7", "cyc released between bursts", 32'(lg_cyc[8]), 2);
    check(sel_bad == 0, "R6", "select not all ones", 32'(sel_bad), 0);
    check(!mismatch, "R8", "no flag on clean read-back", mismatch, 0);
  endtask

  task automatic t_single;
    do_reset(1'b1, 1'b0);
    wait_beats(16);
    for (int j = 0; j < 16; j++) begin
      check(lg_cyc[j] == j + 1, "R4", "one beat per cycle", 32'(lg_cyc[j]), 32'(j + 1));
      check(lg_adr[j] == BASE + 32'(j % 8), "R4", "single address order", lg_adr[j], BASE + 32'(j % 8));
      check(lg_we[j] == (j < 8), "R4", "single write then read", lg_we[j], 32'(j < 8));
    end
    check(!mismatch, "R8", "no flag in single style", mismatch, 0);
  endtask

  task automatic t_wait;
    do_reset(1'b1, 1'b1);
    wait_n = 3;
    wait_beats(16);
    check(hold_bad == 0, "R5", "outputs moved during wait", 32'(hold_bad), 0);
    for (int k = 0; k < 8; k++) begin
      check(lg_adr[k] == BASE + 32'(k), "R5", "step per acked beat", lg_adr[k], BASE + 32'(k));
      check(lg_dat[k] == word_of(k), "R5", "word held across waits", lg_dat[k], word_of(k));
    end
    check(!mismatch, "R8", "no flag with wait states", mismatch, 0);
    wait_n = 0;
  endtask

  task automatic t_corrupt;
    do_reset(1'b1, 1'b1);
    corrupt_idx = 5;
    wait_beats(13);
    check(!mismatch, "R8", "flag before bad read", mismatch, 0);
    wait_beats(14);
    check(mismatch, "R8", "flag after bad read", mismatch, 1);
    corrupt_idx = -1;
    wait_beats(32);
    check(mismatch, "R8", "flag sticky over clean pass", mismatch, 1);
    do_reset(1'b1, 1'b1);
    #2;
    check(!mismatch, "R1", "reset clears flag", mismatch, 0);
  endtask

  task automatic t_mode_mid;
    do_reset(1'b1, 1'b1);
    wait_beats(3);
    @(negedge clk);
    burst_mode = 1'b0;
    wait_beats(10);
    for (int k = 0; k < 8; k++)
      check(lg_cyc[k] == 1, "R9", "burst kept after mode change", 32'(lg_cyc[k]), 1);
    check(lg_cyc[8] == 2, "R9", "next cycle single", 32'(lg_cyc[8]), 2);
    check(lg_cyc[9] == 3, "R9", "following cycle single", 32'(lg_cyc[9]), 3);
  endtask

  initial begin
    t_reset;
    t_no_grant;
    t_block;
    t_single;
    t_wait;
    t_corrupt;
    t_mode_mid;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog run did not finish actual=%h expected=%h", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule